// File: doc/BRIEF.md
# Step/Direction Microstep Sequencer

The sequencer turns a step/direction command stream into coil drive words for a two-phase stepper power stage. It holds a position inside one of four circular step tables of 4, 8, 24 or 72 entries. For the current position it presents two packed 8-bit drive words. A neighbouring mixer applies the primary word for two time units and the secondary word for one. This gives two extra current levels between each pair of hardware levels.

Each STEP rising edge moves the position one entry. DIR chooses the direction. The table is chosen by a 2-bit mode input. That input is captured only at the moment the active-low enable is asserted. The position then restarts at the first entry. While the block is disabled, both drive words are held at zero. All four control inputs are asynchronous to the clock and pass through a synchroniser before any edge detection.

Top module: `microstep_seq`

## Requirements
- R1: While `enable_n_i` is high, including the period during and after reset, both drive words are 0. Stepping while disabled leaves no trace once the block is enabled again.
- R2: When `enable_n_i` is asserted (low), the position restarts at entry 0 of the selected table.
- R3: `mode_i` is captured only when the block becomes enabled. A later change has no effect until the next enable.
- R4: The position moves only on a 0-to-1 transition of STEP. A 1-to-0 transition causes no move.
- R5: A step with DIR high advances the position by one entry. A step with DIR low moves it back by one entry.
- R6: Advancing past the last entry wraps to entry 0. Moving back from entry 0 wraps to the last entry.
- R7: Table lengths by mode code are: 0 gives 4 entries, 1 gives 8, 2 gives 24, 3 gives 72. Stepping the full length in one direction returns to the starting words.
- R8: Word layout: bits 3:0 hold the coil polarity, bits 5:4 hold the phase-B current code, and bits 7:6 hold the phase-A current code. The current codes are 00 = 0%, 01 = 25%, 10 = 55% and 11 = 100%.
- R9: The coil polarity runs 0101, 1001, 1010, 0110 in quarter-table blocks of equal length. Entry 0 starts at 0101.
- R10: In mode 0, every entry has both phases at code 11. In mode 1, even entries have one phase at 11 and the other at 00, and odd entries have both phases at 11.
- R11: In mode 3, entries 3h of each quarter have equal primary and secondary words at hardware level h. Entry 3h+1 has primary at level h and secondary at level h+1. Entry 3h+2 has primary at level h+1 and secondary at level h.
- R12: In mode 2, the primary and secondary words are equal. The hardware levels (A,B) within a quarter run (3,0),(3,1),(3,2),(3,3),(2,3),(1,3), with level 6 being (0,3). In the second and fourth quarters, A and B are swapped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| step_i | input | 1 | Step command, acts on its rising edge (asynchronous) |
| dir_i | input | 1 | Direction: high moves forward, low moves back (asynchronous) |
| enable_n_i | input | 1 | Active-low enable (asynchronous) |
| mode_i | input | 2 | Table select, captured on enable (asynchronous) |
| prim_o | output | 8 | Primary drive word (two thirds of the mixing period) |
| sec_o | output | 8 | Secondary drive word (one third of the mixing period) |

## Verification
The properties assume that each control input holds a new value for more than the synchroniser depth. A STEP high or low phase, a DIR setup before a STEP edge, or a mode setup before enable that is shorter than this may be missed or merged. The properties also assume that the captured mode changes only at an enable. The stimulus drives every input on the falling clock edge. It holds STEP high and low for eight cycles each, and it sets DIR and mode several cycles ahead of the edge that uses them. It then samples both words only after the four-register path from pin to output has settled.

// File: rtl/microstep_pkg.sv
package microstep_pkg;

   localparam int CUR_W  = 2;
   localparam int COIL_W = 4;
   localparam int WORD_W = 2 * CUR_W + COIL_W;
   localparam int QUAD_W = 2;
   localparam int HW_W   = 3;
   localparam int TW_W   = 2;
   localparam int MODE_W = 2;

   typedef enum logic [MODE_W-1:0] {
      MODE_FULL   = 2'd0,
      MODE_HALF   = 2'd1,
      MODE_SIXTH  = 2'd2,
      MODE_THIRDS = 2'd3
   } seq_mode_e;

   typedef struct packed {
      logic [CUR_W-1:0]  cur_a;
      logic [CUR_W-1:0]  cur_b;
      logic [COIL_W-1:0] coils;
   } drive_word_t;

   // polarity pattern for each quarter of the electrical cycle
   function automatic logic [COIL_W-1:0] coil_for_quad(input logic [QUAD_W-1:0] q);
      case (q)
         2'd0:    return 4'b0101;
         2'd1:    return 4'b1001;
         2'd2:    return 4'b1010;
         default: return 4'b0110;
      endcase
   endfunction

   // phase that leaves full current as the hardware level k climbs 0..6
   function automatic logic [CUR_W-1:0] lead_level(input logic [HW_W-1:0] k);
      logic [HW_W-1:0] d;
      d = 3'd6 - k;
      if (k <= 3'd3) return '1;
      return d[CUR_W-1:0];
   endfunction

   // phase that reaches full current as k climbs 0..6
   function automatic logic [CUR_W-1:0] rise_level(input logic [HW_W-1:0] k);
      if (k >= 3'd3) return '1;
      return k[CUR_W-1:0];
   endfunction

   function automatic drive_word_t hw_word(input logic [QUAD_W-1:0] q,
                                           input logic [HW_W-1:0]   k);
      drive_word_t w;
      w.coils = coil_for_quad(q);
      if (!q[0]) begin
         w.cur_a = lead_level(k);
         w.cur_b = rise_level(k);
      end else begin
         w.cur_a = rise_level(k);
         w.cur_b = lead_level(k);
      end
      return w;
   endfunction

   // hardware positions visited per quarter
   function automatic logic [HW_W-1:0] hw_span(input seq_mode_e m);
      case (m)
         MODE_FULL: return 3'd1;
         MODE_HALF: return 3'd2;
         default:   return 3'd6;
      endcase
   endfunction

   // tween slots per hardware position
   function automatic logic [TW_W-1:0] tween_span(input seq_mode_e m);
      if (m == MODE_THIRDS) return 2'd3;
      return 2'd1;
   endfunction

endpackage

// File: rtl/msq_sync.sv
module msq_sync #(
   parameter int               WIDTH     = 1,
   parameter int               STAGES    = 2,
   parameter logic [WIDTH-1:0] RESET_VAL = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d_i,
   output logic [WIDTH-1:0] q_o
);

   if (STAGES < 2) begin : g_bad_depth
      $error("msq_sync: STAGES must be at least 2");
   end
   if (WIDTH < 1) begin : g_bad_width
      $error("msq_sync: WIDTH must be at least 1");
   end

   logic [WIDTH-1:0] stage_q [STAGES];

   for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stage_q[i] <= RESET_VAL;
            else        stage_q[i] <= d_i;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stage_q[i] <= RESET_VAL;
            else        stage_q[i] <= stage_q[i-1];
         end
      end
   end

   assign q_o = stage_q[STAGES-1];

endmodule

// File: rtl/msq_position.sv
module msq_position
   import microstep_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              restart_i,
   input  logic              adv_i,
   input  logic              dir_up_i,
   input  logic [HW_W-1:0]   h_span_i,
   input  logic [TW_W-1:0]   t_span_i,
   output logic [QUAD_W-1:0] quad_o,
   output logic [HW_W-1:0]   hw_o,
   output logic [TW_W-1:0]   tw_o
);

   logic [QUAD_W-1:0] quad_q, quad_n;
   logic [HW_W-1:0]   hw_q, hw_n;
   logic [TW_W-1:0]   tw_q, tw_n;
   logic              t_last, h_last;

   assign t_last = (tw_q == t_span_i - 1'b1);
   assign h_last = (hw_q == h_span_i - 1'b1);

   // chained counters: tween slot, hardware position, quarter
   always_comb begin
      quad_n = quad_q;
      hw_n   = hw_q;
      tw_n   = tw_q;
      if (restart_i) begin
         quad_n = '0;
         hw_n   = '0;
         tw_n   = '0;
      end else if (adv_i) begin
         if (dir_up_i) begin
            if (!t_last) begin
               tw_n = tw_q + 1'b1;
            end else begin
               tw_n = '0;
               if (!h_last) begin
                  hw_n = hw_q + 1'b1;
               end else begin
                  hw_n   = '0;
                  quad_n = quad_q + 1'b1;
               end
            end
         end else begin
            if (tw_q != '0) begin
               tw_n = tw_q - 1'b1;
            end else begin
               tw_n = t_span_i - 1'b1;
               if (hw_q != '0) begin
                  hw_n = hw_q - 1'b1;
               end else begin
                  hw_n   = h_span_i - 1'b1;
                  quad_n = quad_q - 1'b1;
               end
            end
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         quad_q <= '0;
         hw_q   <= '0;
         tw_q   <= '0;
      end else begin
         quad_q <= quad_n;
         hw_q   <= hw_n;
         tw_q   <= tw_n;
      end
   end

   assign quad_o = quad_q;
   assign hw_o   = hw_q;
   assign tw_o   = tw_q;

   AST_HOLD_WITHOUT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (!adv_i && !restart_i) |=> ($stable(quad_q) && $stable(hw_q) && $stable(tw_q))); // R4
   AST_TWEEN_IN_TABLE: assert property (@(posedge clk) disable iff (!rst_n)
      tw_q < t_span_i); // R7
   AST_HW_IN_TABLE: assert property (@(posedge clk) disable iff (!rst_n)
      hw_q < h_span_i); // R7
   AST_WRAP_FORWARD: assert property (@(posedge clk) disable iff (!rst_n)
      (adv_i && dir_up_i && !restart_i && quad_q == 2'd3 && h_last && t_last)
      |=> (quad_q == '0 && hw_q == '0 && tw_q == '0)); // R6
   AST_WRAP_BACKWARD: assert property (@(posedge clk) disable iff (!rst_n)
      (adv_i && !dir_up_i && !restart_i && quad_q == '0 && hw_q == '0 && tw_q == '0)
      |=> (quad_q == 2'd3 && hw_q == $past(h_span_i) - 1'b1 && tw_q == $past(t_span_i) - 1'b1)); // R6

endmodule

// File: rtl/msq_wordgen.sv
module msq_wordgen
   import microstep_pkg::*;
#(
   parameter bit FULL_TWIN = 1'b1
) (
   input  seq_mode_e         mode_i,
   input  logic [QUAD_W-1:0] quad_i,
   input  logic [HW_W-1:0]   hw_i,
   input  logic [TW_W-1:0]   tw_i,
   output drive_word_t       prim_o,
   output drive_word_t       sec_o
);

   logic [HW_W-1:0] full_k;
   logic [HW_W-1:0] base_k;
   logic [HW_W-1:0] next_k;
   drive_word_t     here_w;
   drive_word_t     next_w;

   // full-step variant: both coils at full current, or one coil only
   if (FULL_TWIN) begin : g_twin
      assign full_k = 3'd3;
   end else begin : g_single
      assign full_k = 3'd0;
   end

   always_comb begin
      case (mode_i)
         MODE_FULL: base_k = full_k;
         MODE_HALF: base_k = hw_i[0] ? 3'd3 : 3'd0;
         default:   base_k = hw_i;
      endcase
      next_k = base_k + 1'b1;
      here_w = hw_word(quad_i, base_k);
      next_w = hw_word(quad_i, next_k);
      case (tw_i)
         2'd1: begin
            prim_o = here_w;
            sec_o  = next_w;
         end
         2'd2: begin
            prim_o = next_w;
            sec_o  = here_w;
         end
         default: begin
            prim_o = here_w;
            sec_o  = here_w;
         end
      endcase
   end

endmodule

// File: rtl/microstep_seq.sv
module microstep_seq
   import microstep_pkg::*;
#(
   parameter int SYNC_STAGES    = 2,
   parameter bit FULL_STEP_TWIN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              step_i,
   input  logic              dir_i,
   input  logic              enable_n_i,
   input  logic [MODE_W-1:0] mode_i,
   output logic [WORD_W-1:0] prim_o,
   output logic [WORD_W-1:0] sec_o
);

   localparam int IN_W = MODE_W + 3;
   localparam logic [IN_W-1:0] IN_RESET = IN_W'(3'b100);

   if (WORD_W != 8) begin : g_bad_word
      $error("microstep_seq: drive word must be 8 bits");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("microstep_seq: SYNC_STAGES must be at least 2");
   end

   logic [IN_W-1:0]   raw_in, sync_in;
   logic              step_s, dir_s, en_sync;
   logic [MODE_W-1:0] mode_s;

   assign raw_in = {mode_i, enable_n_i, dir_i, step_i};

   msq_sync #(
      .WIDTH     (IN_W),
      .STAGES    (SYNC_STAGES),
      .RESET_VAL (IN_RESET)
   ) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   (raw_in),
      .q_o   (sync_in)
   );

   assign step_s  = sync_in[0];
   assign dir_s   = sync_in[1];
   assign en_sync = ~sync_in[2];
   assign mode_s  = sync_in[IN_W-1:3];

   logic      step_prev_q;
   logic      active_q;
   seq_mode_e mode_lat;
   logic      step_rise, start, restart, adv;

   assign step_rise = step_s & ~step_prev_q;
   assign start     = en_sync & ~active_q;
   assign restart   = ~en_sync | start;
   assign adv       = step_rise & active_q & en_sync;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         step_prev_q <= 1'b0;
         active_q    <= 1'b0;
         mode_lat    <= MODE_FULL;
      end else begin
         step_prev_q <= step_s;
         active_q    <= en_sync;
         if (start) mode_lat <= seq_mode_e'(mode_s);
      end
   end

   logic [QUAD_W-1:0] quad;
   logic [HW_W-1:0]   hw_pos;
   logic [TW_W-1:0]   tw_pos;

   msq_position u_pos (
      .clk       (clk),
      .rst_n     (rst_n),
      .restart_i (restart),
      .adv_i     (adv),
      .dir_up_i  (dir_s),
      .h_span_i  (hw_span(mode_lat)),
      .t_span_i  (tween_span(mode_lat)),
      .quad_o    (quad),
      .hw_o      (hw_pos),
      .tw_o      (tw_pos)
   );

   drive_word_t prim_w, sec_w;

   msq_wordgen #(
      .FULL_TWIN (FULL_STEP_TWIN)
   ) u_words (
      .mode_i (mode_lat),
      .quad_i (quad),
      .hw_i   (hw_pos),
      .tw_i   (tw_pos),
      .prim_o (prim_w),
      .sec_o  (sec_w)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prim_o <= '0;
         sec_o  <= '0;
      end else if (active_q) begin
         prim_o <= prim_w;
         sec_o  <= sec_w;
      end else begin
         prim_o <= '0;
         sec_o  <= '0;
      end
   end

   AST_OFF_WHILE_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(en_sync) |=> (prim_o == '0 && sec_o == '0)); // R1
   AST_MODE_HELD_WHILE_ON: assert property (@(posedge clk) disable iff (!rst_n)
      (active_q && $past(active_q)) |-> $stable(mode_lat)); // R3
   AST_COILS_TWO_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
      (prim_o != '0) |-> ($countones(prim_o[COIL_W-1:0]) == 2)); // R9
   AST_THIRDS_ANCHOR_EQUAL: assert property (@(posedge clk) disable iff (!rst_n)
      (active_q && mode_lat == MODE_THIRDS && tw_pos == '0) |=> (prim_o == sec_o)); // R11
   AST_SIXTH_WORDS_EQUAL: assert property (@(posedge clk) disable iff (!rst_n)
      (active_q && mode_lat == MODE_SIXTH) |=> (prim_o == sec_o)); // R12

   if (FULL_STEP_TWIN) begin : g_full_chk
      AST_FULL_BOTH_MAX: assert property (@(posedge clk) disable iff (!rst_n)
         (active_q && mode_lat == MODE_FULL)
         |=> (prim_o[WORD_W-1 -: 2*CUR_W] == '1 && sec_o[WORD_W-1 -: 2*CUR_W] == '1)); // R10
   end

endmodule

// File: tb/sim_microstep_seq.sv
module sim_microstep_seq;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       step_i = 1'b0;
   logic       dir_i = 1'b1;
   logic       enable_n_i = 1'b1;
   logic [1:0] mode_i = 2'd0;
   logic [7:0] prim_o, sec_o;

   int checks = 0;
   int errors = 0;
   int cur_mode = 0;
   int idx = 0;

   microstep_seq u0 (
      .clk        (clk),
      .rst_n      (rst_n),
      .step_i     (step_i),
      .dir_i      (dir_i),
      .enable_n_i (enable_n_i),
      .mode_i     (mode_i),
      .prim_o     (prim_o),
      .sec_o      (sec_o)
   );

   always #10ns clk = ~clk;

   function automatic int tab_len(input int m);
      return (m == 0) ? 4 : (m == 1) ? 8 : (m == 2) ? 24 : 72;
   endfunction

   // hardware level word per R8, R9, R12
   function automatic logic [7:0] level_word(input int q, input int k);
      int la [7] = '{3, 3, 3, 3, 2, 1, 0};
      int lb [7] = '{0, 1, 2, 3, 3, 3, 3};
      logic [3:0] c;
      c = (q == 0) ? 4'b0101 : (q == 1) ? 4'b1001 : (q == 2) ? 4'b1010 : 4'b0110;
      if (q % 2 == 0) return {2'(la[k]), 2'(lb[k]), c};
      return {2'(lb[k]), 2'(la[k]), c};
   endfunction

   function automatic logic [15:0] model(input int m, input int i);
      int span, q, e, k, t;
      logic [7:0] a, b;
      span = tab_len(m) / 4;
      q = i / span;
      e = i % span;
      t = 0;
      case (m)
         0:       k = 3;
         1:       k = 3 * e;
         2:       k = e;
         default: begin k = e / 3; t = e % 3; end
      endcase
      a = level_word(q, k);
      b = level_word(q, k + 1);
      if (t == 1) return {a, b};
      if (t == 2) return {b, a};
      return {a, a};
   endfunction

   task automatic wait_clks(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic check(input string tag, input logic [15:0] got, input logic [15:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s: got prim=%b sec=%b expected prim=%b sec=%b",
                  tag, got[15:8], got[7:0], exp[15:8], exp[7:0]);
      end
   endtask

   task automatic check_pos(input string tag);
      check(tag, {prim_o, sec_o}, model(cur_mode, idx));
   endtask

   task automatic do_enable(input int m);
      mode_i = 2'(m);
      wait_clks(4);
      enable_n_i = 1'b0;
      wait_clks(8);
      cur_mode = m;
      idx = 0;
   endtask

   task automatic do_disable();
      enable_n_i = 1'b1;
      wait_clks(8);
   endtask

   task automatic do_step(input bit up);
      dir_i = up;
      wait_clks(4);
      step_i = 1'b1;
      wait_clks(8);
      step_i = 1'b0;
      wait_clks(8);
      idx = up ? (idx + 1) % tab_len(cur_mode) : (idx + tab_len(cur_mode) - 1) % tab_len(cur_mode);
   endtask

   task automatic test_reset();
      wait_clks(3);
      check("R1 zero in reset", {prim_o, sec_o}, 16'h0000);
      rst_n = 1'b1;
      wait_clks(10);
      check("R1 zero while disabled", {prim_o, sec_o}, 16'h0000);
   endtask

   task automatic test_full();
      do_enable(0);
      check_pos("R2 full entry 0");
      check("R10 full entry 0 literal", {prim_o, sec_o}, {8'b11110101, 8'b11110101});
      for (int i = 0; i < 4; i++) begin
         do_step(1'b1);
         check_pos("R5 R9 R10 full forward");
      end
      check("R7 full length 4 returns", {prim_o, sec_o}, model(0, 0));
      do_step(1'b0);
      check_pos("R6 full wrap below 0");
      check("R9 full last entry 0110", {prim_o, sec_o}, {8'b11110110, 8'b11110110});
      do_disable();
   endtask

   task automatic test_half();
      do_enable(1);
      check_pos("R2 half entry 0");
      for (int i = 0; i < 9; i++) begin
         do_step(1'b1);
         check_pos("R10 half forward");
      end
      do_step(1'b0);
      do_step(1'b0);
      check_pos("R6 R5 half back over wrap");
      do_disable();
   endtask

   task automatic test_sixth();
      do_enable(2);
      do_step(1'b1);
      check("R8 sixth entry 1 packing", {prim_o, sec_o}, {8'b11010101, 8'b11010101});
      for (int i = 0; i < 23; i++) begin
         do_step(1'b1);
         check_pos("R12 sixth forward");
         if (idx == 4)
            check("R8 sixth entry 4 packing", {prim_o, sec_o}, {8'b10110101, 8'b10110101});
      end
      check("R7 sixth length 24 returns", {prim_o, sec_o}, model(2, 0));
      for (int i = 0; i < 3; i++) begin
         do_step(1'b0);
         check_pos("R6 sixth backward");
      end
      do_disable();
   endtask

   task automatic test_thirds();
      do_enable(3);
      check_pos("R2 thirds entry 0");
      for (int i = 0; i < 73; i++) begin
         do_step(1'b1);
         check_pos("R11 thirds forward");
      end
      do_step(1'b0);
      do_step(1'b0);
      check_pos("R6 thirds wrap to 71");
      check("R11 thirds entry 71 literal", {prim_o, sec_o}, {8'b11000110, 8'b11010110});
      do_disable();
   endtask

   task automatic test_falling();
      do_enable(2);
      dir_i = 1'b1;
      wait_clks(4);
      step_i = 1'b1;
      wait_clks(8);
      idx = 1;
      check_pos("R4 rising edge moves");
      step_i = 1'b0;
      wait_clks(8);
      check_pos("R4 falling edge no move");
      do_disable();
   endtask

   task automatic test_mode_latch();
      do_enable(2);
      mode_i = 2'd3;
      wait_clks(6);
      do_step(1'b1);
      check_pos("R3 mode change ignored while on");
      do_disable();
      check("R1 off after disable", {prim_o, sec_o}, 16'h0000);
      enable_n_i = 1'b0;
      wait_clks(8);
      cur_mode = 3;
      idx = 0;
      do_step(1'b1);
      check_pos("R3 new mode after re-enable");
      do_disable();
   endtask

   task automatic test_disabled_steps();
      do_enable(2);
      do_step(1'b1);
      do_step(1'b1);
      do_disable();
      for (int i = 0; i < 3; i++) begin
         do_step(1'b1);
         check("R1 zero while stepping disabled", {prim_o, sec_o}, 16'h0000);
      end
      do_enable(2);
      check_pos("R2 restart at entry 0");
      do_disable();
   endtask

   initial begin
      test_reset();
      test_full();
      test_half();
      test_sixth();
      test_thirds();
      test_falling();
      test_mode_latch();
      test_disabled_steps();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      #3ms;
      checks++;
      errors++;
      $display("FAIL watchdog: run did not complete, got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule